// File: doc/BRIEF.md
# Fall-Through Bubble FIFO

This block is a first-in/first-out store made from a chain of identical stages instead of a memory with read and write pointers. Each stage holds one data word and an occupancy marker. On every rising clock edge, an occupied stage whose downstream neighbour is vacant hands its word forward. Words therefore travel toward the output one stage per clock, and empty slots drift back toward the input with no outside control.

A producer offers a word with a shift-in strobe whenever the input-ready status shows the first stage vacant. A consumer reads the word shown at the output while the output-ready status is high, and removes it with a shift-out strobe. Full and empty are read directly from the first and last markers, so no pointer arithmetic or comparison is involved. A synchronous reset empties the chain. Width and depth are parameters, with a default of 16 words of 4 bits.

Top module: `fallThroughFifo`

## Requirements
- R1: When `rst` is high at a rising edge, every stage becomes vacant: after that edge `inReady` is 1 and `outReady` is 0.
- R2: `inReady` is 1 exactly when the input-side stage is vacant. A `shiftIn` pulse while `inReady` is 1 captures `dataIn` into that stage, and `inReady` is 0 after the edge.
- R3: A `shiftIn` pulse while `inReady` is 0 is ignored. No word is added and no stored word is overwritten.
- R4: A word loaded into an empty FIFO makes `outReady` go high right after the DEPTH-th rising edge, counting the edge that loaded it. Before that edge `outReady` stays low.
- R5: A stage becomes occupied only by loading from its occupied upstream neighbour (or, for the first stage, from `dataIn`), so a word moves at most one stage per clock.
- R6: While `outReady` is 1 and `shiftOut` is 0, `outReady` stays 1 and `dataOut` keeps its value.
- R7: A `shiftOut` pulse while `outReady` is 1 removes the output word. Right after that edge `outReady` is 0 and `dataOut` reads all zeros until the next word arrives.
- R8: A `shiftOut` pulse while `outReady` is 0 is ignored. A word written later still arrives intact.
- R9: With no reads, the FIFO accepts exactly DEPTH words and then keeps `inReady` at 0.
- R10: Words leave in the order they were accepted, whatever the spacing of the shift-in and shift-out pulses.
- R11: On every clock edge, the number of occupied stages changes by the number of accepted writes minus the number of accepted removals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; empties all stages |
| shiftIn | input | 1 | Write strobe; acts only while `inReady` is 1 |
| dataIn | input | WIDTH | Word to store |
| inReady | output | 1 | First stage vacant; a write will be accepted |
| shiftOut | input | 1 | Remove strobe; acts only while `outReady` is 1 |
| dataOut | output | WIDTH | Contents of the output-side stage |
| outReady | output | 1 | Output-side stage holds a valid word |

## Verification
The bench targets the ripple latency: a design that moved a word more than one stage per clock, or that stalled it, would raise `outReady` on the wrong edge. It fills the chain with no reads and then keeps pushing a distinct poison word. A design that counted capacity wrongly would accept too few or too many words, and one that overwrote the first stage would let the poison word out during the drain. Removal is checked both on the output stage and on an empty chain. A bad release would show a stale or duplicated word, and an underflow would corrupt later traffic. Finally, a sweep of producer and consumer gap settings compares every word that leaves against an ordered scoreboard. This exposes any reordering or loss when stages advance at the same time as a word is removed.

// File: rtl/fifoPkg.sv
package fifoPkg;

  // Strobes passed from the marker control to the data chain.
  typedef struct packed {
    logic acceptIn;    // first stage takes the input word
    logic releaseOut;  // output stage is emptied by a read
  } fifoStrobes_t;

endpackage

// File: rtl/fifoMarkerCtrl.sv
module fifoMarkerCtrl
  import fifoPkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shiftIn,
  input  logic               shiftOut,
  output logic [DEPTH-1:0]   marker,
  output logic [DEPTH-1:1]   advance,
  output fifoStrobes_t       strobes,
  output logic               inReady,
  output logic               outReady
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] arrive;
  logic [DEPTH-1:0] leave;

  // A stage fills when it is vacant and its source holds a word.
  assign arrive[0] = shiftIn & ~marker[0];

  for (genvar s = 1; s < DEPTH; s++) begin : g_arrive
    assign arrive[s] = marker[s-1] & ~marker[s];
  end

  // A stage empties when its word moves on or is read out.
  for (genvar s = 0; s < LAST; s++) begin : g_leave
    assign leave[s] = marker[s] & ~marker[s+1];
  end
  assign leave[LAST] = marker[LAST] & shiftOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      marker <= '0;
    end else begin
      marker <= (marker & ~leave) | arrive;
    end
  end

  assign advance            = arrive[DEPTH-1:1];
  assign strobes.acceptIn   = arrive[0];
  assign strobes.releaseOut = leave[LAST];
  assign inReady            = ~marker[0];
  assign outReady           = marker[LAST];

endmodule

// File: rtl/fifoDataChain.sv
module fifoDataChain
  import fifoPkg::*;
#(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic [WIDTH-1:0]   dataIn,
  input  logic [DEPTH-1:1]   advance,
  input  fifoStrobes_t       strobes,
  output logic [WIDTH-1:0]   dataOut
);

  localparam int LAST = DEPTH - 1;

  logic [WIDTH-1:0] word [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.acceptIn) begin
      word[0] <= dataIn;
    end
  end

  for (genvar s = 1; s < LAST; s++) begin : g_mid
    always_ff @(posedge clk) begin
      if (advance[s]) begin
        word[s] <= word[s-1];
      end
    end
  end

  // The output stage clears its word on release, so no stale value is shown.
  always_ff @(posedge clk) begin
    if (advance[LAST]) begin
      word[LAST] <= word[LAST-1];
    end else if (strobes.releaseOut) begin
      word[LAST] <= '0;
    end
  end

  assign dataOut = word[LAST];

endmodule

// File: rtl/fallThroughFifo.sv
module fallThroughFifo
  import fifoPkg::*;
#(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shiftIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             inReady,
  input  logic             shiftOut,
  output logic [WIDTH-1:0] dataOut,
  output logic             outReady
);

  logic [DEPTH-1:0] marker;
  logic [DEPTH-1:1] advance;
  fifoStrobes_t     strobes;

  fifoMarkerCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .shiftIn  (shiftIn),
    .shiftOut (shiftOut),
    .marker   (marker),
    .advance  (advance),
    .strobes  (strobes),
    .inReady  (inReady),
    .outReady (outReady)
  );

  fifoDataChain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_data (
    .clk     (clk),
    .dataIn  (dataIn),
    .advance (advance),
    .strobes (strobes),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/fifoChecker.sv
module fifoChecker #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             shiftIn,
  input logic             shiftOut,
  input logic             inReady,
  input logic             outReady,
  input logic [WIDTH-1:0] dataOut,
  input logic [DEPTH-1:0] marker
);

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (inReady && !outReady && marker == '0)); // R1

  AST_ACCEPT_FILLS_FIRST: assert property (@(posedge clk) disable iff (rst)
    (shiftIn && inReady) |=> !inReady); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (outReady && !shiftOut) |=> (outReady && $stable(dataOut))); // R6

  AST_OUT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (outReady && shiftOut) |=> (!outReady && dataOut == '0)); // R7

  AST_OCCUPANCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (int'($countones(marker)) ==
      int'($countones($past(marker))) + int'($past(shiftIn && inReady))
      - int'($past(shiftOut && outReady)))); // R11

  for (genvar s = 1; s < DEPTH; s++) begin : g_step
    AST_ONE_STAGE_STEP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(marker[s])) |-> $past(marker[s-1])); // R5
  end

endmodule

bind fallThroughFifo fifoChecker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifoChecker (
  .clk      (clk),
  .rst      (rst),
  .shiftIn  (shiftIn),
  .shiftOut (shiftOut),
  .inReady  (inReady),
  .outReady (outReady),
  .dataOut  (dataOut),
  .marker   (marker)
);

// File: tb/test_fallThroughFifo.sv
module test_fallThroughFifo;

  localparam int WIDTH  = 4;
  localparam int DEPTH  = 4;
  localparam int NWORDS = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             shiftIn = 1'b0;
  logic             shiftOut = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic             inReady;
  logic             outReady;
  logic [WIDTH-1:0] dataOut;

  int checks = 0;
  int fails  = 0;
  logic [WIDTH-1:0] sb [$];

  always #4 clk = ~clk;

  fallThroughFifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_fallThroughFifo (
    .clk(clk), .rst(rst), .shiftIn(shiftIn), .dataIn(dataIn), .inReady(inReady),
    .shiftOut(shiftOut), .dataOut(dataOut), .outReady(outReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; shiftIn = 1'b0; shiftOut = 1'b0;
    step(); step();
    check(inReady == 1'b1, "R1 inReady", int'(inReady), 1);
    check(outReady == 1'b0, "R1 outReady", int'(outReady), 0);
    rst = 1'b0;
  endtask

  function automatic logic [WIDTH-1:0] pat(input int n, input int salt);
    return WIDTH'((n * 7 + salt * 3 + 1) % (1 << WIDTH));
  endfunction

  initial begin
    @(negedge clk);
    doReset();

    // R4 / R5: latency through an empty chain
    shiftIn = 1'b1; dataIn = 4'hA;
    step();
    shiftIn = 1'b0;
    check(inReady == 1'b0, "R2 first stage taken", int'(inReady), 0);
    for (int k = 1; k < DEPTH; k++) begin
      check(outReady == 1'b0, "R4 R5 early outReady", int'(outReady), 0);
      step();
    end
    check(outReady == 1'b1, "R4 outReady at DEPTH edges", int'(outReady), 1);
    check(dataOut == 4'hA, "R4 data", int'(dataOut), 10);
    for (int k = 0; k < 3; k++) begin
      step();
      check(outReady && dataOut == 4'hA, "R6 hold", int'(dataOut), 10);
    end
    shiftOut = 1'b1;
    step();
    shiftOut = 1'b0;
    check(outReady == 1'b0, "R7 released", int'(outReady), 0);
    check(dataOut == '0, "R7 cleared word", int'(dataOut), 0);

    // R8: reads on an empty chain
    shiftOut = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      check(outReady == 1'b0, "R8 empty read", int'(outReady), 0);
    end
    shiftOut = 1'b0;
    shiftIn = 1'b1; dataIn = 4'h6;
    step();
    shiftIn = 1'b0;
    for (int k = 1; k < DEPTH; k++) step();
    check(outReady && dataOut == 4'h6, "R8 later word intact", int'(dataOut), 6);
    shiftOut = 1'b1; step(); shiftOut = 1'b0;
    check(outReady == 1'b0, "R8 R11 chain empty again", int'(outReady), 0);

    // R9 / R3: fill with no reads, then push a poison word
    begin
      int accepted = 0;
      for (int k = 0; k < 6 * DEPTH; k++) begin
        shiftIn = 1'b0;
        if (inReady) begin
          shiftIn = 1'b1; dataIn = WIDTH'(accepted + 1); accepted++;
        end
        step();
      end
      shiftIn = 1'b0;
      check(accepted == DEPTH, "R9 capacity", accepted, DEPTH);
      check(inReady == 1'b0, "R9 full", int'(inReady), 0);
      shiftIn = 1'b1; dataIn = 4'hF;
      for (int k = 0; k < 2 * DEPTH; k++) begin
        step();
        check(inReady == 1'b0, "R3 R9 stays full", int'(inReady), 0);
      end
      shiftIn = 1'b0;
      for (int n = 1; n <= DEPTH; n++) begin
        int guard = 0;
        while (!outReady && guard < 4 * DEPTH) begin step(); guard++; end
        check(dataOut == WIDTH'(n), "R3 R10 drain order", int'(dataOut), n);
        shiftOut = 1'b1; step(); shiftOut = 1'b0;
        check(dataOut == '0 && !outReady, "R7 gap after read", int'(dataOut), 0);
      end
      for (int k = 0; k < 2 * DEPTH; k++) step();
      check(outReady == 1'b0, "R3 R11 no extra word", int'(outReady), 0);
    end

    // R10: sweep of producer and consumer spacing
    for (int gIn = 0; gIn < 3; gIn++) begin
      for (int gOut = 0; gOut < 3; gOut++) begin
        int sent = 0, got = 0, inCnt = 0, outCnt = 0, guard = 0;
        doReset();
        sb.delete();
        while (got < NWORDS && guard < 2000) begin
          shiftIn = 1'b0; shiftOut = 1'b0;
          if (outReady && outCnt >= gOut) begin
            logic [WIDTH-1:0] exp;
            exp = (sb.size() > 0) ? sb.pop_front() : '0;
            check(dataOut == exp, "R10 order", int'(dataOut), int'(exp));
            shiftOut = 1'b1; got++; outCnt = 0;
          end else begin
            outCnt++;
          end
          if (sent < NWORDS && inCnt >= gIn && inReady) begin
            shiftIn = 1'b1; dataIn = pat(sent, gIn + gOut);
            sb.push_back(dataIn); sent++; inCnt = 0;
          end else begin
            inCnt++;
          end
          step();
          guard++;
        end
        shiftIn = 1'b0; shiftOut = 1'b0;
        check(got == NWORDS, "R10 R11 all words out", got, NWORDS);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule